// File: doc/BRIEF.md
# Black Level Offset Calibration Controller

This block closes the digital loop that holds a sensor channel's black level at a programmed code. While an active-low calibration window is held low, it collects ADC samples from the masked black pixels at the start of a line. It adds these samples over a programmable number of lines and divides the total down to one average. It then compares the average with a target code. The result is applied to a fine offset DAC code. A coarse DAC code moves one step per update whenever the fine range runs out.

During each black window the block raises a pedestal flag. The analog path uses this flag to lift the signal by 255 codes, so negative offsets are not clipped. The loop removes that pedestal again before it compares the average with the target. Either DAC can be taken out of the loop and driven from a programmed code. When a DAC goes back into the loop, the loop continues from the programmed code.

Top module: `obcal_loop`

## Requirements
- R1: The pixels collected per line are 2^N, where N is `pix_exp_i`. Any N above 6 is treated as 6 (64 pixels). When `triple_i` is 1 the count is three times that (3 up to 192), and the average is formed by a divide-by-3 after the power-of-two shift.
- R2: The lines averaged before each update are 2^L, where L is `line_exp_i`. Any L above 8 is treated as 8 (256 lines).
- R3: A falling edge of `win_ni` starts a line. The first sample after the edge is discarded, and the next P samples are collected. `pedestal_o` is high for exactly P+3 clock cycles from the cycle after the edge. A further falling edge while a line is in progress is ignored.
- R4: At an update the block forms the error e = average − 255 − `target_i`. When the new fine value f − e lies within ±255, it becomes the fine code and the coarse code is unchanged.
- R5: When f − e exceeds +255, the fine code saturates at +255 and the coarse code goes up by one. When f − e is below −255, the fine code saturates at −255 and the coarse code goes down by one. The coarse magnitude never exceeds 255.
- R6: Codes are 9 bits. Bit 8 is the sign (0 positive, 1 negative) and bits 7:0 are the magnitude. A zero result is always written as positive. Both codes reset to 0.
- R7: While `fine_byp_i` is 1, `fine_o` follows `fine_prog_i` one cycle later, and no automatic update touches either code. The coarse code then holds, unless it is bypassed itself.
- R8: While `coarse_byp_i` is 1 and `fine_byp_i` is 0, the fine loop still runs (saturating as in R5), and `coarse_o` follows `coarse_prog_i`.
- R9: When a DAC leaves bypass, the next automatic update starts from the code it last held, which is the programmed code.
- R10: A one-cycle pulse on `clr_i` discards the partial sum and the count of completed lines. The next update is formed only from lines collected after the pulse.
- R11: The codes change only at the update that follows the final line of a pass, or through bypass. Between updates they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adc_i | input | 10 | ADC sample, one per clock |
| win_ni | input | 1 | Calibration window, active low; its falling edge starts a line |
| target_i | input | 10 | Desired black level code |
| pix_exp_i | input | 3 | Pixel count exponent N |
| triple_i | input | 1 | Multiply the pixel count by three |
| line_exp_i | input | 4 | Line count exponent L |
| fine_byp_i | input | 1 | Take the fine DAC out of the loop (this also stops the coarse loop) |
| coarse_byp_i | input | 1 | Take the coarse DAC out of the loop |
| fine_prog_i | input | 9 | Programmed fine code, sign-magnitude |
| coarse_prog_i | input | 9 | Programmed coarse code, sign-magnitude |
| clr_i | input | 1 | Discard the accumulated black result |
| fine_o | output | 9 | Fine offset DAC code |
| coarse_o | output | 9 | Coarse offset DAC code |
| pedestal_o | output | 1 | Add the 255-code pedestal |

## Verification
On every cycle, the assertions check four things about the DAC codes and the window logic:
- the codes hold between updates;
- the coarse code is frozen while the fine DAC is bypassed;
- the coarse code moves by at most one step per update;
- no negative zero is ever written, and a falling window edge always raises the pedestal.

Only the bench scenarios can show the things that depend on a whole pass:
- the averaged values and the clamping of N and L;
- the exact pedestal length and the divide-by-3 path;
- the saturation split between fine and coarse, and the resumption from programmed codes;
- that a clear removes lines already collected.

// File: rtl/obcal_pkg.sv
package obcal_pkg;
  localparam int ADC_W        = 10;
  localparam int MAG_W        = 8;
  localparam int CODE_W       = MAG_W + 1;
  localparam int PIX_EXP_MAX  = 6;
  localparam int LINE_EXP_MAX = 8;
  localparam int PEXP_W       = 3;
  localparam int LEXP_W       = 4;
  localparam int PED          = 255;
  // pixel count (x3) times lines times sample
  localparam int ACC_W        = ADC_W + PIX_EXP_MAX + 2 + LINE_EXP_MAX;
  localparam int AVG_W        = ADC_W + 2;
  localparam int SH_W         = 5;

  typedef logic [CODE_W-1:0] code_t;

  function automatic int sm_to_int(input code_t c);
    int m;
    m = int'(c[MAG_W-1:0]);
    return c[MAG_W] ? -m : m;
  endfunction

  function automatic code_t int_to_sm(input int v);
    int m;
    logic [MAG_W-1:0] mb;
    m  = (v < 0) ? -v : v;
    mb = m[MAG_W-1:0];
    return {(v < 0), mb};
  endfunction
endpackage

// File: rtl/obcal_window.sv
module obcal_window
  import obcal_pkg::*;
#(
  parameter int AW      = ADC_W,
  parameter int PMAX    = PIX_EXP_MAX,
  parameter int LMAX    = LINE_EXP_MAX,
  parameter int PW      = PEXP_W,
  parameter int LW      = LEXP_W,
  parameter int SW      = ACC_W,
  parameter int SHW     = SH_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          win_ni,
  input  logic [AW-1:0] adc_i,
  input  logic [PW-1:0] pix_exp_i,
  input  logic          triple_i,
  input  logic [LW-1:0] line_exp_i,
  input  logic          clr_i,
  output logic          pedestal_o,
  output logic          done_o,
  output logic [SW-1:0] sum_o,
  output logic [SHW-1:0] shift_o
);
  localparam int PCNT_W = $clog2(3 * (2 ** PMAX) + 3) + 1;
  localparam int LCNT_W = LMAX + 1;

  logic [PW-1:0]     n_eff;
  logic [LW-1:0]     l_eff;
  logic [PCNT_W-1:0] npix, pix_cnt;
  logic [LCNT_W-1:0] nlines, line_cnt;
  logic [SW-1:0]     acc, sum_q;
  logic              win_q, active_q, done_q, start;

  always_comb begin
    n_eff  = (pix_exp_i > PW'(PMAX)) ? PW'(PMAX) : pix_exp_i;
    l_eff  = (line_exp_i > LW'(LMAX)) ? LW'(LMAX) : line_exp_i;
    npix   = triple_i ? (PCNT_W'(3) << n_eff) : (PCNT_W'(1) << n_eff);
    nlines = LCNT_W'(1) << l_eff;
  end

  assign start = win_q && !win_ni && !active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q    <= 1'b1;
      active_q <= 1'b0;
      pix_cnt  <= '0;
      line_cnt <= '0;
      acc      <= '0;
      sum_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      win_q  <= win_ni;
      done_q <= 1'b0;
      if (clr_i) begin
        active_q <= 1'b0;
        line_cnt <= '0;
        acc      <= '0;
      end else if (start) begin
        active_q <= 1'b1;
        pix_cnt  <= '0;
      end else if (active_q) begin
        pix_cnt <= pix_cnt + 1'b1;
        // sample 0 is dropped while the front end settles
        if (pix_cnt != '0 && pix_cnt <= npix)
          acc <= acc + SW'(adc_i);
        if (pix_cnt == npix + PCNT_W'(2)) begin
          active_q <= 1'b0;
          if (line_cnt == nlines - 1'b1) begin
            line_cnt <= '0;
            sum_q    <= acc;
            acc      <= '0;
            done_q   <= 1'b1;
          end else begin
            line_cnt <= line_cnt + 1'b1;
          end
        end
      end
    end
  end

  assign pedestal_o = active_q;
  assign done_o     = done_q;
  assign sum_o      = sum_q;
  assign shift_o    = SHW'(n_eff) + SHW'(l_eff);

  a_r3_ped_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q && !win_ni && !active_q && !clr_i) |=> pedestal_o);
  a_r2_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/obcal_div3.sv
module obcal_div3 #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dvd_i,
  output logic         done_o,
  output logic [W-1:0] quo_o
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  dvd_q;
  logic [1:0]    rem_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    trial;
  logic          ge;
  logic          done_q;

  assign trial = {rem_q, dvd_q[W-1]};
  assign ge    = trial >= 3'd3;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        dvd_q <= dvd_i;
        rem_q <= '0;
        cnt_q <= CW'(W);
      end else if (cnt_q != '0) begin
        rem_q  <= ge ? 2'(trial - 3'd3) : trial[1:0];
        dvd_q  <= {dvd_q[W-2:0], ge};
        cnt_q  <= cnt_q - 1'b1;
        done_q <= (cnt_q == CW'(1));
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = dvd_q;

  a_r1_rem_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_q != 2'd3);
endmodule

// File: rtl/obcal_dac_update.sv
module obcal_dac_update
  import obcal_pkg::*;
#(
  parameter int AW = ADC_W,
  parameter int VW = AVG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          upd_i,
  input  logic [VW-1:0] avg_i,
  input  logic [AW-1:0] target_i,
  input  logic          fine_byp_i,
  input  logic          coarse_byp_i,
  input  code_t         fine_prog_i,
  input  code_t         coarse_prog_i,
  output code_t         fine_o,
  output code_t         coarse_o
);
  localparam int FS = 2 ** MAG_W - 1;

  code_t fine_q, coarse_q, fine_n, coarse_n;
  logic  coarse_auto;
  int    err, want, cur_c, nxt_c;

  assign coarse_auto = !coarse_byp_i && !fine_byp_i;

  always_comb begin
    err   = int'(avg_i) - PED - int'(target_i);
    want  = sm_to_int(fine_q) - err;
    cur_c = sm_to_int(coarse_q);
    nxt_c = cur_c;
    if (want > FS) begin
      fine_n = int_to_sm(FS);
      if (cur_c < FS) nxt_c = cur_c + 1;
    end else if (want < -FS) begin
      fine_n = int_to_sm(-FS);
      if (cur_c > -FS) nxt_c = cur_c - 1;
    end else begin
      fine_n = int_to_sm(want);
    end
    coarse_n = int_to_sm(nxt_c);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fine_q   <= '0;
      coarse_q <= '0;
    end else begin
      if (fine_byp_i)       fine_q <= fine_prog_i;
      else if (upd_i)       fine_q <= fine_n;
      if (coarse_byp_i)     coarse_q <= coarse_prog_i;
      else if (upd_i && coarse_auto) coarse_q <= coarse_n;
    end
  end

  assign fine_o   = fine_q;
  assign coarse_o = coarse_q;

  a_r11_fine_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !fine_byp_i) |=> $stable(fine_q));
  a_r7_coarse_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fine_byp_i && !coarse_byp_i) |=> $stable(coarse_q));
  a_r5_coarse_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && coarse_auto) |=>
      ((sm_to_int(coarse_q) - sm_to_int($past(coarse_q)) <= 1) &&
       (sm_to_int(coarse_q) - sm_to_int($past(coarse_q)) >= -1)));
  a_r6_no_neg_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !fine_byp_i) |=> (fine_q != {1'b1, {MAG_W{1'b0}}}));
endmodule

// File: rtl/obcal_loop.sv
module obcal_loop
  import obcal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADC_W-1:0]  adc_i,
  input  logic              win_ni,
  input  logic [ADC_W-1:0]  target_i,
  input  logic [PEXP_W-1:0] pix_exp_i,
  input  logic              triple_i,
  input  logic [LEXP_W-1:0] line_exp_i,
  input  logic              fine_byp_i,
  input  logic              coarse_byp_i,
  input  logic [CODE_W-1:0] fine_prog_i,
  input  logic [CODE_W-1:0] coarse_prog_i,
  input  logic              clr_i,
  output logic [CODE_W-1:0] fine_o,
  output logic [CODE_W-1:0] coarse_o,
  output logic              pedestal_o
);
  logic             done;
  logic [ACC_W-1:0] sum;
  logic [SH_W-1:0]  shift;
  logic [AVG_W-1:0] avg_raw, quo, avg;
  logic             div_done, upd;

  obcal_window u_window (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .win_ni     (win_ni),
    .adc_i      (adc_i),
    .pix_exp_i  (pix_exp_i),
    .triple_i   (triple_i),
    .line_exp_i (line_exp_i),
    .clr_i      (clr_i),
    .pedestal_o (pedestal_o),
    .done_o     (done),
    .sum_o      (sum),
    .shift_o    (shift)
  );

  assign avg_raw = AVG_W'(sum >> shift);

  obcal_div3 #(.W(AVG_W)) u_div3 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (done && triple_i),
    .dvd_i   (avg_raw),
    .done_o  (div_done),
    .quo_o   (quo)
  );

  assign avg = triple_i ? quo : avg_raw;
  assign upd = triple_i ? div_done : done;

  obcal_dac_update u_dac (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .upd_i         (upd),
    .avg_i         (avg),
    .target_i      (target_i),
    .fine_byp_i    (fine_byp_i),
    .coarse_byp_i  (coarse_byp_i),
    .fine_prog_i   (fine_prog_i),
    .coarse_prog_i (coarse_prog_i),
    .fine_o        (fine_o),
    .coarse_o      (coarse_o)
  );
endmodule

// File: tb/obcal_loop_bench.sv
module obcal_loop_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [9:0] adc_i = '0;
  logic       win_ni = 1'b1;
  logic [9:0] target_i = 10'd64;
  logic [2:0] pix_exp_i = 3'd0;
  logic       triple_i = 1'b0;
  logic [3:0] line_exp_i = 4'd0;
  logic       fine_byp_i = 1'b0;
  logic       coarse_byp_i = 1'b0;
  logic [8:0] fine_prog_i = '0;
  logic [8:0] coarse_prog_i = '0;
  logic       clr_i = 1'b0;
  logic [8:0] fine_o, coarse_o;
  logic       pedestal_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  obcal_loop u_obcal_loop (
    .clk_i(clk), .rst_ni(rst_ni), .adc_i(adc_i), .win_ni(win_ni),
    .target_i(target_i), .pix_exp_i(pix_exp_i), .triple_i(triple_i),
    .line_exp_i(line_exp_i), .fine_byp_i(fine_byp_i),
    .coarse_byp_i(coarse_byp_i), .fine_prog_i(fine_prog_i),
    .coarse_prog_i(coarse_prog_i), .clr_i(clr_i), .fine_o(fine_o),
    .coarse_o(coarse_o), .pedestal_o(pedestal_o)
  );

  typedef struct packed {
    logic [2:0] n;
    logic       tr;
    logic [3:0] l;
    logic [9:0] adc;
    logic [9:0] tgt;
    logic [8:0] fine;
    logic [8:0] coarse;
  } vec_t;

  // expected codes carry over from one row to the next
  localparam vec_t VEC [6] = '{
    '{3'd3, 1'b0, 4'd0, 10'd335,  10'd64, 9'h110, 9'h000}, // R4 R6 small negative
    '{3'd0, 1'b1, 4'd1, 10'd315,  10'd64, 9'h10C, 9'h000}, // R1 triple, R2 two lines
    '{3'd7, 1'b0, 4'd0, 10'd619,  10'd64, 9'h1FF, 9'h101}, // R1 clamp, R5 down
    '{3'd2, 1'b1, 4'd9, 10'd219,  10'd64, 9'h19B, 9'h101}, // R2 clamp 256 lines
    '{3'd1, 1'b0, 4'd2, 10'd0,    10'd64, 9'h0A4, 9'h101}, // R4 sign change
    '{3'd0, 1'b0, 4'd0, 10'd1023, 10'd0,  9'h1FF, 9'h102}  // R5 down again
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int npix_of(input logic [2:0] n, input logic tr);
    int ne = (n > 3'd6) ? 6 : int'(n);
    return tr ? (3 << ne) : (1 << ne);
  endfunction

  function automatic int nlines_of(input logic [3:0] l);
    int le = (l > 4'd8) ? 8 : int'(l);
    return 1 << le;
  endfunction

  task automatic run_line(input logic [9:0] v, input int np);
    @(negedge clk);
    adc_i  = v;
    win_ni = 1'b0;
    repeat (np + 6) @(negedge clk);
    win_ni = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_pass(input logic [2:0] n, input logic tr, input logic [3:0] l,
                          input logic [9:0] v, input logic [9:0] tgt);
    pix_exp_i = n; triple_i = tr; line_exp_i = l; target_i = tgt;
    for (int i = 0; i < nlines_of(l); i++) run_line(v, npix_of(n, tr));
    repeat (25) @(negedge clk);
  endtask

  task automatic ped_len(input logic [2:0] n, input logic tr, output int cnt);
    pix_exp_i = n; triple_i = tr; line_exp_i = 4'd0; target_i = 10'd64;
    adc_i = 10'd319; // zero error, codes stay put
    cnt = 0;
    @(negedge clk);
    win_ni = 1'b0;
    repeat (npix_of(n, tr) + 10) begin
      @(negedge clk);
      if (pedestal_o) cnt++;
    end
    win_ni = 1'b1;
    repeat (25) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    // reset state, R6 R11
    chk("R6 reset fine", int'(fine_o), 0);
    chk("R6 reset coarse", int'(coarse_o), 0);
    chk("R3 reset pedestal", int'(pedestal_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    foreach (VEC[i]) begin
      run_pass(VEC[i].n, VEC[i].tr, VEC[i].l, VEC[i].adc, VEC[i].tgt);
      chk($sformatf("R4 R5 vec%0d fine", i), int'(fine_o), int'(VEC[i].fine));
      chk($sformatf("R5 R1 R2 vec%0d coarse", i), int'(coarse_o), int'(VEC[i].coarse));
    end

    // R3 pedestal lengths
    ped_len(3'd2, 1'b0, c);
    chk("R3 pedestal N2", c, 7);
    ped_len(3'd1, 1'b1, c);
    chk("R3 pedestal N1 x3", c, 9);
    chk("R4 zero error fine", int'(fine_o), 'h1FF);

    // R7 fine bypass freezes both loops
    fine_byp_i = 1'b1; fine_prog_i = 9'h120;
    repeat (2) @(negedge clk);
    chk("R7 fine follows prog", int'(fine_o), 'h120);
    run_pass(3'd0, 1'b0, 4'd0, 10'd1023, 10'd0);
    chk("R7 fine held", int'(fine_o), 'h120);
    chk("R7 coarse held", int'(coarse_o), 'h102);

    // R9 resume from programmed fine code
    fine_byp_i = 1'b0;
    run_pass(3'd0, 1'b0, 4'd0, 10'd327, 10'd64);
    chk("R9 fine resumes", int'(fine_o), 'h128);

    // R8 coarse bypass with fine auto
    coarse_byp_i = 1'b1; coarse_prog_i = 9'h005;
    run_pass(3'd0, 1'b0, 4'd0, 10'd1023, 10'd0);
    chk("R8 fine saturates", int'(fine_o), 'h1FF);
    chk("R8 coarse follows prog", int'(coarse_o), 'h005);
    coarse_byp_i = 1'b0;
    run_pass(3'd0, 1'b0, 4'd0, 10'd0, 10'd64);
    chk("R9 fine in range", int'(fine_o), 'h040);
    chk("R9 coarse kept", int'(coarse_o), 'h005);
    run_pass(3'd0, 1'b0, 4'd0, 10'd0, 10'd64);
    chk("R5 fine top", int'(fine_o), 'h0FF);
    chk("R5 R9 coarse up from prog", int'(coarse_o), 'h006);

    // R10 clear drops the first line of a two-line pass
    pix_exp_i = 3'd0; triple_i = 1'b0; line_exp_i = 4'd1; target_i = 10'd64;
    run_line(10'd1023, 1);
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
    run_line(10'd329, 1);
    repeat (20) @(negedge clk);
    chk("R11 no update mid pass", int'(fine_o), 'h0FF);
    run_line(10'd329, 1);
    repeat (20) @(negedge clk);
    chk("R10 clear discards line", int'(fine_o), 'h0F5);
    chk("R10 coarse", int'(coarse_o), 'h006);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule